// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block walks a small table of conversion command words on behalf of an analog-to-digital converter. The table is split into a high-priority queue and a low-priority queue, each with its own start pointer, trigger input and mode. When a queue is triggered, its command words are fetched one after another. Each one becomes a single conversion request to an external converter, which answers with a one-cycle done pulse.

A command word whose pause flag is set closes a subqueue. The queue then waits for a fresh trigger and continues at the following word. A word with the end flag, or the last table entry, completes the queue. A continuous queue rewinds to its start and accepts the next trigger. A single-scan queue ignores triggers until it is re-armed.

The high-priority queue preempts the low-priority one. The low-priority conversion in flight is allowed to finish, but it is not counted. The low-priority queue resumes afterwards, either from its start or from the start of the interrupted subqueue, as selected by a control input.

Top module: `cq_sequencer`

## Requirements
- R1: After reset both status outputs read idle (code 0), `conv_req` is low and both overrun flags are low. Status codes are 0 idle, 1 active, 2 paused, 3 pending and 4 complete.
- R2: Table entry i sits at bits [i*(CHAN_W+2) +: CHAN_W+2] of `cmd_table`. Within an entry, bit 0 is the pause flag, bit 1 is the end flag and the upper CHAN_W bits are the channel. A running queue requests its entries in table order from its start pointer, one request at a time. `conv_chan` carries the entry's channel and `conv_src` carries the queue (0 high, 1 low). `conv_req` stays high, with both fields stable, until `conv_done`.
- R3: When the done pulse arrives for an entry with the pause flag set, the queue reports paused (2) and makes no request until a new trigger arrives. That trigger continues at the next entry.
- R4: When the done pulse arrives for an entry with the end flag set, or for entry DEPTH-1, the queue reports complete (4). In single-scan mode (`qN_cont`=0), triggers are then ignored until an arm pulse returns the queue to idle at its start pointer. In continuous mode, the next trigger restarts at the start pointer.
- R5: With `qN_edge`=1, only a 0-to-1 transition of `qN_trig` is a trigger, so holding the input high starts nothing more. With `qN_edge`=0, every cycle in which `qN_trig` is high is a trigger.
- R6: A trigger that arrives while its queue is active or pending is ignored and sets that queue's overrun flag. The flag stays set until an accepted arm pulse clears it.
- R7: When both queues are triggered in the same cycle, the high queue becomes active and issues first, and the low queue reports pending (3).
- R8: If the high queue is triggered while the low queue is converting, the high queue reports pending. The low conversion finishes, but it does not advance the low queue. The high queue then issues, and the low queue reports pending until the high queue pauses or completes.
- R9: With `q2_resume_sub`=0, a preempted low queue restarts at `q2_start`. With `q2_resume_sub`=1, it restarts at the first entry of the interrupted subqueue.
- R10: An arm pulse is ignored while its queue is active or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_table | input | DEPTH*(CHAN_W+2) | Command table, one packed entry per slot |
| q1_start | input | $clog2(DEPTH) | High queue start pointer |
| q2_start | input | $clog2(DEPTH) | Low queue start pointer |
| q1_cont | input | 1 | High queue continuous (1) or single-scan (0) |
| q2_cont | input | 1 | Low queue continuous (1) or single-scan (0) |
| q1_edge | input | 1 | High queue rising-edge (1) or level (0) trigger |
| q2_edge | input | 1 | Low queue rising-edge (1) or level (0) trigger |
| q2_resume_sub | input | 1 | Low queue resumes at subqueue start (1) or queue start (0) |
| q1_trig | input | 1 | High queue trigger |
| q2_trig | input | 1 | Low queue trigger |
| q1_arm | input | 1 | High queue re-arm pulse |
| q2_arm | input | 1 | Low queue re-arm pulse |
| conv_done | input | 1 | Converter finished the current request |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | CHAN_W | Channel of the current request |
| conv_src | output | 1 | Queue owning the current request (0 high, 1 low) |
| q1_status | output | 3 | High queue status code |
| q2_status | output | 3 | Low queue status code |
| q1_overrun | output | 1 | High queue trigger overrun flag |
| q2_overrun | output | 1 | Low queue trigger overrun flag |

## Verification
Two events can land in the same clock cycle: a high-queue trigger can arrive while the low queue's conversion is in flight or is completing, and both queues can be triggered at once. The bench provokes the first by pulsing the high trigger between the low queue's request and its done pulse, under both resume settings. It judges the outcome by the channel of the low queue's next request. The second is provoked by pulsing both triggers in one cycle, then reading the two status codes and the order of `conv_src` values.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [2:0] {
        QS_IDLE    = 3'd0,
        QS_ACTIVE  = 3'd1,
        QS_PAUSED  = 3'd2,
        QS_PENDING = 3'd3,
        QS_DONE    = 3'd4
    } qstat_e;

    typedef enum logic {
        SRC_HI = 1'b0,
        SRC_LO = 1'b1
    } qsrc_e;

    typedef struct packed {
        logic stop;   // end of queue
        logic hold;   // end of subqueue
    } ccw_flags_t;

    function automatic logic is_running(qstat_e s);
        return (s == QS_ACTIVE) || (s == QS_PENDING);
    endfunction

    function automatic logic takes_trigger(qstat_e s, logic cont);
        return (s == QS_IDLE) || (s == QS_PAUSED) || ((s == QS_DONE) && cont);
    endfunction

endpackage

// File: rtl/cq_trig_detect.sv
module cq_trig_detect (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic edge_mode,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_in;
    end

    always_comb evt = edge_mode ? (trig_in & ~prev_q) : trig_in;
endmodule

// File: rtl/cq_queue_ctrl.sv
module cq_queue_ctrl
    import cq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic          arm,
    input  logic          cont,
    input  logic [PW-1:0] start,
    input  logic          resume_sub,
    input  ccw_flags_t    flags,
    input  logic          go_pending,
    input  logic          issue,
    input  logic          done,
    input  logic          preempt,
    output qstat_e        state,
    output logic [PW-1:0] ptr,
    output logic          accept,
    output logic          overrun
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] sub_q;
    logic          hit;
    logic          arm_ok;
    logic          ends_queue;

    always_comb begin
        accept     = evt && takes_trigger(state, cont);
        hit        = evt && is_running(state);
        arm_ok     = arm && !is_running(state);
        ends_queue = flags.stop || (ptr == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= QS_IDLE;
            ptr     <= start;
            sub_q   <= start;
            overrun <= 1'b0;
        end else begin
            if (hit)         overrun <= 1'b1;
            else if (arm_ok) overrun <= 1'b0;

            if (preempt) begin
                state <= QS_PENDING;
                ptr   <= resume_sub ? sub_q : start;
            end else if (done) begin
                if (ends_queue) begin
                    state <= QS_DONE;
                    ptr   <= start;
                    sub_q <= start;
                end else if (flags.hold) begin
                    state <= QS_PAUSED;
                    ptr   <= ptr + PW'(1);
                    sub_q <= ptr + PW'(1);
                end else begin
                    ptr   <= ptr + PW'(1);
                end
            end else if (issue) begin
                state <= QS_ACTIVE;
            end else if (accept) begin
                state <= go_pending ? QS_PENDING : QS_ACTIVE;
            end else if (arm_ok) begin
                state <= QS_IDLE;
                ptr   <= start;
                sub_q <= start;
            end
        end
    end
endmodule

// File: rtl/cq_dispatch.sv
module cq_dispatch
    import cq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  qstat_e            st_hi,
    input  qstat_e            st_lo,
    input  logic [CHAN_W-1:0] chan_hi,
    input  logic [CHAN_W-1:0] chan_lo,
    input  logic              conv_done,
    output logic              busy,
    output qsrc_e             owner,
    output logic [CHAN_W-1:0] chan,
    output logic              iss_hi,
    output logic              iss_lo
);
    always_comb begin
        iss_hi = !busy && is_running(st_hi);
        iss_lo = !busy && !is_running(st_hi) && is_running(st_lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= SRC_HI;
            chan  <= '0;
        end else if (busy) begin
            if (conv_done) busy <= 1'b0;
        end else if (iss_hi) begin
            busy  <= 1'b1;
            owner <= SRC_HI;
            chan  <= chan_hi;
        end else if (iss_lo) begin
            busy  <= 1'b1;
            owner <= SRC_LO;
            chan  <= chan_lo;
        end
    end
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
    import cq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CHAN_W = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CCW_W = CHAN_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DEPTH*CCW_W-1:0] cmd_table,
    input  logic [PW-1:0]          q1_start,
    input  logic [PW-1:0]          q2_start,
    input  logic                   q1_cont,
    input  logic                   q2_cont,
    input  logic                   q1_edge,
    input  logic                   q2_edge,
    input  logic                   q2_resume_sub,
    input  logic                   q1_trig,
    input  logic                   q2_trig,
    input  logic                   q1_arm,
    input  logic                   q2_arm,
    input  logic                   conv_done,
    output logic                   conv_req,
    output logic [CHAN_W-1:0]      conv_chan,
    output logic                   conv_src,
    output logic [2:0]             q1_status,
    output logic [2:0]             q2_status,
    output logic                   q1_overrun,
    output logic                   q2_overrun
);
    // index 0 = high-priority queue, index 1 = low-priority queue
    logic [1:0]       trig_v, edge_v, cont_v, arm_v, resume_v;
    logic [PW-1:0]    start_v [2];
    logic [1:0]       evt, acc, ovr, go_pend, issue_v, done_v, preempt_v;
    qstat_e           st  [2];
    logic [PW-1:0]    ptr [2];
    logic [CCW_W-1:0] ent [2];
    ccw_flags_t       flg [2];

    logic  busy, iss_hi, iss_lo, owner_lo;
    qsrc_e owner;

    always_comb begin
        trig_v     = {q2_trig, q1_trig};
        edge_v     = {q2_edge, q1_edge};
        cont_v     = {q2_cont, q1_cont};
        arm_v      = {q2_arm, q1_arm};
        resume_v   = {q2_resume_sub, 1'b0};
        start_v[0] = q1_start;
        start_v[1] = q2_start;
    end

    for (genvar g = 0; g < 2; g++) begin : g_q
        always_comb begin
            ent[g] = cmd_table[ptr[g]*CCW_W +: CCW_W];
            flg[g] = ent[g][1:0];
        end

        cq_trig_detect u_trig (
            .clk       (clk),
            .rst       (rst),
            .trig_in   (trig_v[g]),
            .edge_mode (edge_v[g]),
            .evt       (evt[g])
        );

        cq_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .evt        (evt[g]),
            .arm        (arm_v[g]),
            .cont       (cont_v[g]),
            .start      (start_v[g]),
            .resume_sub (resume_v[g]),
            .flags      (flg[g]),
            .go_pending (go_pend[g]),
            .issue      (issue_v[g]),
            .done       (done_v[g]),
            .preempt    (preempt_v[g]),
            .state      (st[g]),
            .ptr        (ptr[g]),
            .accept     (acc[g]),
            .overrun    (ovr[g])
        );
    end

    cq_dispatch #(.CHAN_W(CHAN_W)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .st_hi     (st[0]),
        .st_lo     (st[1]),
        .chan_hi   (ent[0][CCW_W-1:2]),
        .chan_lo   (ent[1][CCW_W-1:2]),
        .conv_done (conv_done),
        .busy      (busy),
        .owner     (owner),
        .chan      (conv_chan),
        .iss_hi    (iss_hi),
        .iss_lo    (iss_lo)
    );

    always_comb begin
        owner_lo   = busy && (owner == SRC_LO);
        issue_v    = {iss_lo, iss_hi};
        // high queue waits while the low queue owns or is taking the converter
        go_pend[0] = owner_lo || iss_lo;
        go_pend[1] = is_running(st[0]) || acc[0];
        preempt_v[0] = 1'b0;
        preempt_v[1] = (owner_lo && conv_done && ((st[0] == QS_PENDING) || acc[0]))
                     || (iss_hi && (st[1] == QS_ACTIVE));
        done_v[0]  = busy && (owner == SRC_HI) && conv_done;
        done_v[1]  = owner_lo && conv_done && !preempt_v[1];
    end

    assign conv_req   = busy;
    assign conv_src   = (owner == SRC_LO);
    assign q1_status  = st[0];
    assign q2_status  = st[1];
    assign q1_overrun = ovr[0];
    assign q2_overrun = ovr[1];
endmodule

// File: rtl/cq_sequencer_chk.sv
module cq_sequencer_chk #(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_req,
    input logic              conv_done,
    input logic              conv_src,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [2:0]        q1_status,
    input logic [2:0]        q2_status,
    input logic              q1_arm,
    input logic              q2_arm,
    input logic              q1_overrun,
    input logic              q2_overrun
);
    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        conv_req && !conv_done |=> conv_req);

    p_req_stable_r2: assert property (@(posedge clk) disable iff (rst)
        conv_req && !conv_done |=> $stable(conv_chan) && $stable(conv_src));

    p_paused_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (q1_status == 3'd2) && conv_req |-> conv_src);

    p_ovr_clear_q1_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(q1_overrun) |-> $past(q1_arm));

    p_ovr_clear_q2_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(q2_overrun) |-> $past(q2_arm));

    p_one_active_r7: assert property (@(posedge clk) disable iff (rst)
        !((q1_status == 3'd1) && (q2_status == 3'd1)));

    p_owner_hi_r8: assert property (@(posedge clk) disable iff (rst)
        conv_req && !conv_src |-> q1_status == 3'd1);

    p_owner_lo_r8: assert property (@(posedge clk) disable iff (rst)
        conv_req && conv_src |-> q2_status == 3'd1);
endmodule

bind cq_sequencer cq_sequencer_chk #(.CHAN_W(CHAN_W)) u_chk (.*);

// File: tb/cq_sequencer_test.sv
module cq_sequencer_test;
    localparam int DEPTH  = 16;
    localparam int CHAN_W = 4;
    localparam int CCW_W  = CHAN_W + 2;
    localparam int PW     = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [DEPTH*CCW_W-1:0] cmd_table = '0;
    logic [PW-1:0]          q1_start = '0, q2_start = PW'(8);
    logic q1_cont = 0, q2_cont = 0, q1_edge = 0, q2_edge = 0, q2_resume_sub = 0;
    logic q1_trig = 0, q2_trig = 0, q1_arm = 0, q2_arm = 0, conv_done = 0;
    logic                   conv_req, conv_src, q1_overrun, q2_overrun;
    logic [CHAN_W-1:0]      conv_chan;
    logic [2:0]             q1_status, q2_status;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    cq_sequencer #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) uut (.*);

    function automatic int chan_of(int i);
        return (i * 5 + 3) % 16;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_table(input int pmask, input int emask);
        for (int i = 0; i < DEPTH; i++)
            cmd_table[i*CCW_W +: CCW_W] = {CHAN_W'(chan_of(i)), emask[i], pmask[i]};
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(input int q);
        if (q == 0) q1_trig = 1; else q2_trig = 1;
        @(negedge clk);
        if (q == 0) q1_trig = 0; else q2_trig = 0;
    endtask

    task automatic arm_q(input int q);
        if (q == 0) q1_arm = 1; else q2_arm = 1;
        @(negedge clk);
        q1_arm = 0; q2_arm = 0;
    endtask

    task automatic wait_req(input int src, input int idx, input string req);
        int n = 0;
        while (!conv_req && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({req, " request"}, int'(conv_req), 1);
        chk({req, " source"}, int'(conv_src), src);
        chk({req, " channel"}, int'(conv_chan), chan_of(idx));
    endtask

    task automatic finish_req();
        @(negedge clk);
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
    endtask

    task automatic serve(input int src, input int idx, input string req);
        wait_req(src, idx, req);
        finish_req();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        load_table(0, 1 << 5);
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1 q1 status", int'(q1_status), 0);
        chk("R1 q2 status", int'(q2_status), 0);
        chk("R1 conv_req", int'(conv_req), 0);
        chk("R1 overrun", int'({q1_overrun, q2_overrun}), 0);

        // R2 R3 R4 sweep over the pause position, level single-scan
        for (int p = 0; p < 4; p++) begin
            arm_q(0);
            load_table(1 << p, 1 << 5);
            pulse_trig(0);
            for (int k = 0; k <= p; k++) serve(0, k, "R2 first subqueue");
            chk("R3 paused", int'(q1_status), 2);
            cyc(3);
            chk("R3 no request while paused", int'(conv_req), 0);
            pulse_trig(0);
            for (int k = p + 1; k <= 5; k++) serve(0, k, "R3 next subqueue");
            chk("R4 complete", int'(q1_status), 4);
        end
        pulse_trig(0);
        cyc(3);
        chk("R4 single-scan ignores trigger", int'(conv_req), 0);
        chk("R4 stays complete", int'(q1_status), 4);
        chk("R6 no overrun when complete", int'(q1_overrun), 0);
        arm_q(0);
        chk("R4 arm returns to idle", int'(q1_status), 0);
        load_table(0, 1 << 1);
        pulse_trig(0);
        serve(0, 0, "R4 restart at start");
        serve(0, 1, "R4 restart second");

        // R5 R6 R10 edge trigger, continuous
        q1_edge = 1; q1_cont = 1;
        arm_q(0);
        q1_trig = 1;
        serve(0, 0, "R5 edge start");
        serve(0, 1, "R5 edge second");
        chk("R4 continuous complete", int'(q1_status), 4);
        cyc(5);
        chk("R5 held trigger no restart", int'(conv_req), 0);
        q1_trig = 0;
        cyc(1);
        q1_trig = 1;
        wait_req(0, 0, "R4 continuous rewind");
        q1_trig = 0;
        cyc(1);
        q1_trig = 1;
        cyc(1);
        chk("R6 overrun set", int'(q1_overrun), 1);
        arm_q(0);
        chk("R10 arm ignored overrun", int'(q1_overrun), 1);
        chk("R10 arm ignored status", int'(q1_status), 1);
        finish_req();
        serve(0, 1, "R6 run continues");
        cyc(3);
        chk("R6 no extra run", int'(conv_req), 0);
        arm_q(0);
        chk("R6 arm clears overrun", int'(q1_overrun), 0);
        chk("R6 arm to idle", int'(q1_status), 0);
        q1_trig = 0; q1_edge = 0; q1_cont = 0;

        // R7 simultaneous triggers
        load_table(0, (1 << 1) | (1 << 9));
        arm_q(1);
        q1_trig = 1; q2_trig = 1;
        cyc(1);
        q1_trig = 0; q2_trig = 0;
        chk("R7 high active", int'(q1_status), 1);
        chk("R7 low pending", int'(q2_status), 3);
        serve(0, 0, "R7 high first");
        serve(0, 1, "R7 high second");
        serve(1, 8, "R7 low after high");
        serve(1, 9, "R7 low second");
        chk("R7 low complete", int'(q2_status), 4);

        // R8 R9 preemption and resume policy
        for (int rs = 0; rs < 2; rs++) begin
            q2_resume_sub = rs[0];
            load_table(1 << 9, (1 << 0) | (1 << 13));
            arm_q(0);
            arm_q(1);
            pulse_trig(1);
            serve(1, 8, "R8 low sub one");
            serve(1, 9, "R8 low sub one end");
            chk("R3 low paused", int'(q2_status), 2);
            pulse_trig(1);
            wait_req(1, 10, "R8 low sub two");
            pulse_trig(0);
            chk("R8 high pending", int'(q1_status), 3);
            finish_req();
            chk("R8 low pending after abort", int'(q2_status), 3);
            serve(0, 0, "R8 high runs");
            chk("R8 high complete", int'(q1_status), 4);
            if (rs == 0) begin
                serve(1, 8, "R9 resume at queue start");
                serve(1, 9, "R9 queue start second");
                chk("R9 paused again", int'(q2_status), 2);
            end else begin
                serve(1, 10, "R9 resume at subqueue start");
                for (int k = 11; k <= 13; k++) serve(1, k, "R9 subqueue rest");
                chk("R9 complete", int'(q2_status), 4);
            end
        end

        cyc(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule